// File: doc/BRIEF.md
# Serial FPGA Configuration Loader

This block is a bus master that loads a configuration bitstream into a target FPGA over a one-bit serial configuration link. Bytes come in on a valid/ready stream, with a flag that marks the last byte. The block drives three lines to the target: a program request, a serial clock and a serial data bit. It watches two status lines from the target: an init indicator and a done indicator. Both are modelled active-high at the ports. Any polarity inversion belongs in the pad ring.

A load starts with a single-cycle `start` pulse. The block first puts the target into its clear state and confirms it. Then it releases the target and waits until the target is ready for data. Each byte is shifted out most significant bit first. At every byte boundary the block checks for a CRC fault from the target. After the last byte it keeps clocking with the data line high until the target reports done.

Every pin change is held for a fixed number of system clocks. Every wait on the target has a timeout, also counted in system clocks. The result appears as a status code that stays valid until the next start. A request to read the configuration back cannot be served over this link, so it is answered at once with a rejection code.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset the block reports `busy`=0 and `status`=0. It drives `prog_o`, `cclk_o`, `din_o` and `s_ready` low.
- R2: A `start` pulse while idle raises `prog_o` until `init_i` goes high. If `init_i` stays low for TIMEOUT_CYC clocks, the block stops with `prog_o` low and `status`=2. In that case `busy` is high for exactly TIMEOUT_CYC cycles.
- R3: Once `init_i` is seen high, `prog_o` is released and the block waits for `init_i` to fall before any data is taken. If `init_i` stays high for TIMEOUT_CYC clocks, the load ends with `status`=3.
- R4: Each accepted byte produces exactly eight rising edges of `cclk_o`, carrying bit 7 first and bit 0 last. `din_o` does not change in the cycle in which `cclk_o` rises.
- R5: Every high phase of `cclk_o` lasts exactly PHASE_CYC system clocks.
- R6: `s_ready` is high only when no bit of a byte is in flight, the target's init has cleared, and the serial clock is low. This means a byte is accepted only at a byte boundary.
- R7: If `init_i` is high while `done_i` is low at a byte boundary, the load stops with `status`=4. No further byte is accepted and no further clock edge is issued.
- R8: After the byte flagged by `s_last`, `din_o` is held at 1 and one extra `cclk_o` pulse is issued per check while `done_i` is low. When `done_i` is seen high, the load ends with `status`=1. No extra pulse follows.
- R9: If `done_i` does not rise within TIMEOUT_CYC clocks of the last data bit, the load ends with `status`=5.
- R10: A `readback_req` pulse while idle sets `status`=6 on the next clock. `busy` stays low and no target pin moves.
- R11: `busy` is high from the clock after `start` until the final status is written, and `status` reads 0 throughout that time. The final status holds until the next `start`. `start` and `readback_req` have no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse: begin a load |
| readback_req | input | 1 | Pulse: request a readback (always rejected) |
| s_data | input | DATA_W | Bitstream byte |
| s_valid | input | 1 | Stream byte valid |
| s_last | input | 1 | Marks the final byte of the bitstream |
| s_ready | output | 1 | Byte taken on this clock when `s_valid` is high |
| init_i | input | 1 | Target init indicator, high = active |
| done_i | input | 1 | Target done indicator, high = configured |
| prog_o | output | 1 | Program request to target, high = clear the target |
| cclk_o | output | 1 | Serial configuration clock; target samples on its rising edge |
| din_o | output | 1 | Serial configuration data |
| busy | output | 1 | Load in progress |
| status | output | 3 | Result: 0 none, 1 ok, 2 init-enter timeout, 3 init-exit timeout, 4 CRC fault, 5 done timeout, 6 readback rejected |

## Verification
A corrupted bit counter or shift register shows up at the target model as a mismatched byte within the same byte, or as a byte accepted while the serial clock count is not a multiple of eight. A stuck state shows as a missing status code. It also shows as a `busy` window whose length differs from the timeout, which is visible the cycle the wait should have ended. A wrong fill or CRC decision shows as an extra or missing clock pulse and a wrong final code. The bench measures each of these after every load: byte contents, pulse count, high-phase width, timeout length and the handshake position.

// File: rtl/cfg_sloader_pkg.sv
package cfg_sloader_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ENTER,
        S_EXIT,
        S_FETCH,
        S_BIT_LO,
        S_BIT_SET,
        S_BIT_HI,
        S_FILL_CHK,
        S_FILL_LO,
        S_FILL_HI
    } ld_state_t;

    typedef enum logic [2:0] {
        RES_NONE        = 3'd0,
        RES_OK          = 3'd1,
        RES_TO_ENTER    = 3'd2,
        RES_TO_EXIT     = 3'd3,
        RES_CRC         = 3'd4,
        RES_TO_DONE     = 3'd5,
        RES_NO_READBACK = 3'd6
    } ld_result_t;

    // Timeout group: the long-wait timer restarts only when the group changes.
    function automatic logic [1:0] wait_group(ld_state_t s);
        case (s)
            S_ENTER:                         return 2'd1;
            S_EXIT:                          return 2'd2;
            S_FILL_CHK, S_FILL_LO, S_FILL_HI: return 2'd3;
            default:                         return 2'd0;
        endcase
    endfunction

    function automatic logic crc_fault(logic init_act, logic done_act);
        return init_act & ~done_act;
    endfunction

endpackage

// File: rtl/cfg_phase_timer.sv
module cfg_phase_timer #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic hit
);
    localparam int unsigned W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    assign hit = (cnt == W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (!hit) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cfg_byte_shifter.sv
module cfg_byte_shifter #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] data_in,
    input  logic              shift,
    output logic              msb,
    output logic              last_bit
);
    localparam int unsigned IW = $clog2(BYTE_W);

    logic [BYTE_W-1:0] sh;
    logic [IW-1:0]     idx;

    assign msb      = sh[BYTE_W-1];
    assign last_bit = (idx == IW'(BYTE_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '0;
            idx <= '0;
        end else if (load) begin
            sh  <= data_in;
            idx <= '0;
        end else if (shift) begin
            sh  <= {sh[BYTE_W-2:0], 1'b0};
            idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfg_sloader_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned PHASE_CYC   = 2,
    parameter int unsigned TIMEOUT_CYC = 500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              readback_req,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_valid,
    input  logic              s_last,
    output logic              s_ready,
    input  logic              init_i,
    input  logic              done_i,
    output logic              prog_o,
    output logic              cclk_o,
    output logic              din_o,
    output logic              busy,
    output logic [2:0]        status
);
    ld_state_t  state, nstate;
    ld_result_t result;
    logic       din_r, last_r;
    logic       pace_hit, wait_hit, pace_clr, wait_clr;
    logic       fault, accept, bit_msb, bit_last, bit_shift;

    assign fault     = crc_fault(init_i, done_i);
    assign s_ready   = (state == S_FETCH) && !fault;
    assign accept    = s_ready && s_valid;
    assign bit_shift = (state == S_BIT_HI) && pace_hit;
    assign pace_clr  = (nstate != state);
    assign wait_clr  = (wait_group(nstate) != wait_group(state));

    cfg_phase_timer #(.LIMIT(PHASE_CYC)) u_pace (
        .clk(clk), .rst(rst), .clr(pace_clr), .hit(pace_hit)
    );

    cfg_phase_timer #(.LIMIT(TIMEOUT_CYC)) u_wait (
        .clk(clk), .rst(rst), .clr(wait_clr), .hit(wait_hit)
    );

    cfg_byte_shifter #(.BYTE_W(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .load(accept), .data_in(s_data),
        .shift(bit_shift), .msb(bit_msb), .last_bit(bit_last)
    );

    always_comb begin
        nstate = state;
        case (state)
            S_IDLE:     if (start) nstate = S_ENTER;
            S_ENTER:    if (init_i) nstate = S_EXIT;
                        else if (wait_hit) nstate = S_IDLE;
            S_EXIT:     if (!init_i) nstate = S_FETCH;
                        else if (wait_hit) nstate = S_IDLE;
            S_FETCH:    if (fault) nstate = S_IDLE;
                        else if (s_valid) nstate = S_BIT_LO;
            S_BIT_LO:   if (pace_hit) nstate = S_BIT_SET;
            S_BIT_SET:  if (pace_hit) nstate = S_BIT_HI;
            S_BIT_HI:   if (pace_hit) begin
                            if (!bit_last) nstate = S_BIT_LO;
                            else if (last_r) nstate = S_FILL_CHK;
                            else nstate = S_FETCH;
                        end
            S_FILL_CHK: if (done_i || wait_hit) nstate = S_IDLE;
                        else nstate = S_FILL_LO;
            S_FILL_LO:  if (pace_hit) nstate = S_FILL_HI;
            S_FILL_HI:  if (pace_hit) nstate = S_FILL_CHK;
            default:    nstate = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            result <= RES_NONE;
            din_r  <= 1'b0;
            last_r <= 1'b0;
        end else begin
            state <= nstate;
            case (state)
                S_IDLE: begin
                    din_r <= 1'b0;
                    if (start) result <= RES_NONE;
                    else if (readback_req) result <= RES_NO_READBACK;
                end
                S_ENTER:    if (!init_i && wait_hit) result <= RES_TO_ENTER;
                S_EXIT:     if (init_i && wait_hit) result <= RES_TO_EXIT;
                S_FETCH:    if (fault) result <= RES_CRC;
                S_BIT_LO:   if (pace_hit) din_r <= bit_msb;
                S_FILL_CHK: begin
                    din_r <= 1'b1;
                    if (done_i) result <= RES_OK;
                    else if (wait_hit) result <= RES_TO_DONE;
                end
                default: ;
            endcase
            if (accept) last_r <= s_last;
        end
    end

    assign busy   = (state != S_IDLE);
    assign prog_o = (state == S_ENTER);
    assign cclk_o = (state == S_BIT_HI) || (state == S_FILL_HI);
    assign din_o  = din_r;
    assign status = result;
endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       readback_req,
    input logic       s_ready,
    input logic       init_i,
    input logic       done_i,
    input logic       prog_o,
    input logic       cclk_o,
    input logic       din_o,
    input logic       busy,
    input logic [2:0] status
);
    p_prog_in_load_r2: assert property (@(posedge clk) disable iff (rst)
        prog_o |-> busy);

    p_din_setup_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(cclk_o) |-> $stable(din_o));

    p_ready_boundary_r6: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> (!cclk_o && !prog_o && busy));

    p_ready_no_fault_r7: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> !(init_i && !done_i));

    p_reject_r10: assert property (@(posedge clk) disable iff (rst)
        (readback_req && !start && !busy) |=> (status == 3'd6 && !busy));

    p_status_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start && !readback_req) |=> $stable(status));

    p_running_code_r11: assert property (@(posedge clk) disable iff (rst)
        busy |-> (status == 3'd0));
endmodule

bind cfg_serial_loader cfg_serial_loader_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .readback_req(readback_req),
    .s_ready(s_ready), .init_i(init_i), .done_i(done_i), .prog_o(prog_o),
    .cclk_o(cclk_o), .din_o(din_o), .busy(busy), .status(status)
);

// File: tb/cfg_serial_loader_tb.sv
module cfg_serial_loader_tb;
    localparam int PHASE = 2;
    localparam int TMO   = 300;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0, readback_req = 1'b0;
    logic [7:0] s_data = '0;
    logic       s_valid = 1'b0, s_last = 1'b0, s_ready;
    logic       init_i = 1'b0, done_i = 1'b0;
    logic       prog_o, cclk_o, din_o, busy;
    logic [2:0] status;

    cfg_serial_loader #(.DATA_W(8), .PHASE_CYC(PHASE), .TIMEOUT_CYC(TMO)) u_dut (
        .clk(clk), .rst(rst), .start(start), .readback_req(readback_req),
        .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
        .init_i(init_i), .done_i(done_i), .prog_o(prog_o), .cclk_o(cclk_o),
        .din_o(din_o), .busy(busy), .status(status)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    logic [7:0] tx_mem [16];
    logic [7:0] rx_mem [16];
    logic [7:0] rx_sh;
    int rx_bits, exp_bits, fill_cnt, fill_zero, width_bad, bound_bad, accepted;
    longint t_rise;
    int tphase, pcnt, xcnt, enter_dly, exit_dly, done_after, crc_at;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    // Target receiver: samples data on rising serial clock
    initial forever begin
        @(posedge cclk_o);
        t_rise = $time;
        if (rx_bits < exp_bits) begin
            rx_sh = {rx_sh[6:0], din_o};
            if ((rx_bits % 8) == 7) rx_mem[rx_bits / 8] = rx_sh;
        end else begin
            fill_cnt++;
            if (!din_o) fill_zero++;
        end
        rx_bits++;
    end

    initial forever begin
        @(negedge cclk_o);
        if (($time - t_rise) != longint'(PHASE * 20)) width_bad++;
    end

    // Target status model, updated shortly after each system clock edge
    initial forever begin
        @(posedge clk);
        #2;
        case (tphase)
            0: if (prog_o) begin
                   pcnt++;
                   if (enter_dly >= 0 && pcnt >= enter_dly) begin init_i = 1'b1; tphase = 1; end
               end
            1: if (!prog_o) begin
                   xcnt++;
                   if (exit_dly >= 0 && xcnt >= exit_dly) begin init_i = 1'b0; tphase = 2; end
               end
            default: begin
                if (crc_at >= 0 && rx_bits >= crc_at) init_i = 1'b1;
                if (done_after >= 0 && rx_bits >= exp_bits && fill_cnt >= done_after) done_i = 1'b1;
            end
        endcase
    end

    task automatic tgt_reset(int en, int ex, int dn, int crc, int nbytes);
        tphase = 0; pcnt = 0; xcnt = 0;
        enter_dly = en; exit_dly = ex; done_after = dn; crc_at = crc;
        init_i = 1'b0; done_i = 1'b0;
        rx_bits = 0; rx_sh = '0; exp_bits = 8 * nbytes;
        fill_cnt = 0; fill_zero = 0; width_bad = 0; bound_bad = 0; accepted = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic send_stream(int n);
        for (int i = 0; i < n; i++) begin
            repeat ($urandom_range(0, 2)) @(negedge clk);
            s_data = tx_mem[i]; s_last = (i == n - 1); s_valid = 1'b1;
            while (!s_ready && busy) @(negedge clk);
            if (s_ready) begin
                if ((rx_bits % 8) != 0 || tphase != 2) bound_bad++;
                accepted++;
                @(negedge clk);
            end
            s_valid = 1'b0; s_last = 1'b0;
            if (!busy) break;
        end
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 20000 && busy; g++) @(negedge clk);
    endtask

    task automatic good_load(int n, bit inject);
        int en, ex, dn;
        en = $urandom_range(1, 20); ex = $urandom_range(1, 20); dn = $urandom_range(0, 5);
        for (int i = 0; i < n; i++) tx_mem[i] = 8'($urandom);
        tgt_reset(en, ex, dn, -1, n);
        pulse_start();
        chk(busy == 1'b1 && status == 3'd0, "R11", "busy/status after start", {29'd0, busy, status[1:0]}, 4);
        if (inject) begin
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0; readback_req = 1'b1;
            @(negedge clk); readback_req = 1'b0;
        end
        send_stream(n);
        wait_idle();
        chk(status == 3'd1, "R8", "load status", int'(status), 1);
        chk(fill_cnt == dn, "R8", "fill pulses", fill_cnt, dn);
        chk(fill_zero == 0, "R8", "fill bits low", fill_zero, 0);
        chk(rx_bits == 8 * n + dn, "R4", "total clock edges", rx_bits, 8 * n + dn);
        for (int i = 0; i < n; i++)
            chk(rx_mem[i] == tx_mem[i], "R4", $sformatf("byte %0d", i), int'(rx_mem[i]), int'(tx_mem[i]));
        chk(width_bad == 0, "R5", "clock high width errors", width_bad, 0);
        chk(bound_bad == 0, "R6", "accept off boundary", bound_bad, 0);
        chk(accepted == n, "R6", "bytes accepted", accepted, n);
        repeat (10) @(negedge clk);
        chk(status == 3'd1 && !busy, "R11", "status held", int'(status), 1);
    endtask

    initial begin
        int cyc;
        void'($urandom(32'd20240611));
        tgt_reset(-1, -1, -1, -1, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
        chk(status == 3'd0, "R1", "status", int'(status), 0);
        chk({prog_o, cclk_o, din_o, s_ready} == 4'b0, "R1", "pins", int'({prog_o, cclk_o, din_o, s_ready}), 0);

        // R10 readback rejected
        readback_req = 1'b1;
        @(negedge clk); readback_req = 1'b0;
        chk(status == 3'd6 && !busy, "R10", "readback status", int'(status), 6);
        cyc = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (prog_o || cclk_o || busy) cyc++;
        end
        chk(cyc == 0, "R10", "pin activity after reject", cyc, 0);

        // R4 R5 R6 R8 normal loads
        for (int k = 0; k < 4; k++) good_load($urandom_range(1, 6), 1'b0);
        // R11 start/readback while busy ignored
        good_load(3, 1'b1);

        // R2 init never enters
        tgt_reset(-1, -1, -1, -1, 2);
        pulse_start();
        cyc = 0;
        while (busy && cyc < 5000) begin cyc++; @(negedge clk); end
        chk(cyc == TMO, "R2", "busy cycles before timeout", cyc, TMO);
        chk(status == 3'd2, "R2", "enter timeout status", int'(status), 2);
        chk(prog_o == 1'b0, "R2", "prog released", int'(prog_o), 0);

        // R3 init never clears
        tgt_reset(3, -1, -1, -1, 2);
        tx_mem[0] = 8'hA5; tx_mem[1] = 8'h3C;
        pulse_start();
        send_stream(2);
        wait_idle();
        chk(status == 3'd3, "R3", "exit timeout status", int'(status), 3);
        chk(accepted == 0 && rx_bits == 0, "R3", "data before init cleared", accepted + rx_bits, 0);

        // R7 CRC fault in byte two
        tgt_reset(2, 4, 0, 12, 4);
        for (int i = 0; i < 4; i++) tx_mem[i] = 8'($urandom);
        pulse_start();
        send_stream(4);
        wait_idle();
        chk(status == 3'd4, "R7", "crc status", int'(status), 4);
        chk(rx_bits == 16, "R7", "clock edges", rx_bits, 16);
        chk(accepted == 2, "R7", "bytes accepted", accepted, 2);

        // R9 done never rises
        tgt_reset(1, 1, -1, -1, 2);
        tx_mem[0] = 8'h00; tx_mem[1] = 8'hFF;
        pulse_start();
        send_stream(2);
        wait_idle();
        chk(status == 3'd5, "R9", "done timeout status", int'(status), 5);
        chk(fill_cnt > 0, "R9", "fill pulses issued", fill_cnt, 1);
        chk(fill_zero == 0, "R8", "fill bits low in timeout", fill_zero, 0);

        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end
endmodule